// File: doc/BRIEF.md
# Aggregated multi-buffer linked-list queue manager

This block keeps many packet queues as singly linked lists of nodes. Each node covers a fixed group of `AGG` adjacent cell buffers in packet memory. The caller supplies a queue number with every cell. On an enqueue the block returns the buffer ID where that cell must be written. On a dequeue it returns the buffer ID to read next from that queue. Buffer IDs are not stored anywhere. They are formed by shifting the node number left by log2(`AGG`) and adding the offset inside the node.

Each queue has a descriptor in flops. It holds the head node, the tail node, a head offset, a tail offset and an empty flag. The link to the next node of a queue sits in a small next-pointer RAM. That RAM's read latency is a parameter, `LINK_LAT`. Unused nodes are chained through the same RAM into a last-in first-out free list.

A node is taken from the free list only when the tail node of the queue is full. A node goes back to the free list when its last buffer has been read or when the queue drains. So the link RAM is touched once per `AGG` cells, not once per cell. When an operation has to wait for a link read, the block lowers its ready output for `LINK_LAT` cycles.

Top module: `aggq_mgr`

## Requirements
- R1: After reset all queues are empty, `cmd_ready` is 1, `rsp_valid` is 0, and all `NUM_NODES` nodes are free. Exactly `NUM_NODES*AGG` enqueues succeed before one fails.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. In the cycle after an accepted command, `rsp_valid` is 1. In every other cycle it is 0.
- R3: The buffer ID is node × `AGG` + offset. An enqueue whose tail node is not full returns the previous tail buffer ID plus one.
- R4: An enqueue to an empty queue, or to a queue whose tail offset is `AGG-1`, takes a node from the free list. It returns that node's offset-0 buffer. After reset, nodes are handed out in ascending order 0, 1, 2, ….
- R5: Dequeues on a queue return that queue's buffer IDs in the same order as they were enqueued (`cmd_deq`=1 means dequeue, 0 means enqueue).
- R6: A dequeue releases the head node when it reads offset `AGG-1` or when it empties the queue. A released node goes to the front of the free list and is the next node allocated.
- R7: A dequeue on an empty queue returns `rsp_err`=1 with `rsp_buf`=0 and changes no state.
- R8: An enqueue that needs a node while the free list is empty returns `rsp_err`=1 with `rsp_buf`=0 and changes no state.
- R9: `cmd_ready` is 0 for exactly `LINK_LAT` cycles after an accepted command that either allocates a node or releases a head node while cells remain in the queue. After any other command it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_deq | input | 1 | 1 = dequeue, 0 = enqueue |
| cmd_qid | input | clog2(NUM_Q) | Target queue |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| rsp_valid | output | 1 | Response for the command accepted in the previous cycle |
| rsp_buf | output | clog2(NUM_NODES)+clog2(AGG) | Buffer ID to write (enqueue) or read (dequeue) |
| rsp_err | output | 1 | Empty queue on dequeue, or no free node on enqueue |

## Verification
The bench builds the block with 4 queues, 8 nodes, `AGG`=4 and `LINK_LAT`=2. With only 8 nodes, the free list can be drained completely in a few dozen commands, so the out-of-nodes error and its recovery are easy to reach. A link latency of 2 shows that the stall really spans several cycles, and that the link read returns data from before the write made in the same cycle. Directed sequences and a long pseudo-random mix of commands across all queues are compared against a behavioural model. That model tracks only per-queue lists of buffer IDs and a free-node list.

// File: rtl/aggq_pkg.sv
package aggq_pkg;
   // kind of link-RAM read still in flight
   typedef enum logic [1:0] {
      PK_NONE    = 2'd0,
      PK_ALLOC   = 2'd1,
      PK_ADVANCE = 2'd2
   } pend_kind_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/aggq_link_ram.sv
module aggq_link_ram #(
   parameter int DEPTH = 16,
   parameter int LAT   = 1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [AW-1:0] wdata,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output logic [AW-1:0] rdata
);
   localparam int CW = $clog2(LAT + 1);

   logic [AW-1:0] mem [DEPTH];
   logic [CW-1:0] inflight;

   // reset chains node i to node i+1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= AW'((i + 1) % DEPTH);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   generate
      if (LAT == 1) begin : g_lat1
         logic [AW-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[raddr];
         assign rdata = rd_q;
      end else begin : g_latn
         logic [AW-1:0] pipe [LAT];
         always_ff @(posedge clk) begin
            pipe[0] <= mem[raddr];
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
         end
         assign rdata = pipe[LAT-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           inflight <= '0;
      else if (rd_en)       inflight <= CW'(LAT);
      else if (inflight != 0) inflight <= inflight - 1'b1;
   end

   // R9: a new link read never starts while an earlier one is in flight
   p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (inflight == 0));
endmodule

// File: rtl/aggq_buf_map.sv
module aggq_buf_map #(
   parameter int NW  = 4,
   parameter int AGG = 4,
   localparam int SH = $clog2(AGG),
   localparam int OW = (SH > 0) ? SH : 1
) (
   input  logic [NW-1:0]    node,
   input  logic [OW-1:0]    off,
   output logic [NW+SH-1:0] buf_id
);
   generate
      if (AGG == 1) begin : g_unit
         logic unused_off;
         assign unused_off = ^off;
         assign buf_id = node;
      end else begin : g_shift
         assign buf_id = {node, off};
      end
   endgenerate
endmodule

// File: rtl/aggq_mgr.sv
module aggq_mgr
   import aggq_pkg::*;
#(
   parameter int NUM_Q     = 4,
   parameter int NUM_NODES = 16,
   parameter int AGG       = 4,
   parameter int LINK_LAT  = 1,
   localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
   localparam int NW = $clog2(NUM_NODES),
   localparam int SH = $clog2(AGG),
   localparam int BW = NW + SH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_deq,
   input  logic [QW-1:0] cmd_qid,
   output logic          cmd_ready,
   output logic          rsp_valid,
   output logic [BW-1:0] rsp_buf,
   output logic          rsp_err
);
   localparam int OW = (SH > 0) ? SH : 1;
   localparam int CW = $clog2(NUM_NODES + 1);
   localparam int LW = $clog2(LINK_LAT + 1);

   generate
      if (!is_pow2(AGG))   begin : g_bad_agg   $error("AGG must be a power of two"); end
      if (!is_pow2(NUM_NODES) || NUM_NODES < 2)
                           begin : g_bad_nodes $error("NUM_NODES must be a power of two >= 2"); end
      if (LINK_LAT < 1)    begin : g_bad_lat   $error("LINK_LAT must be at least 1"); end
      if (NUM_Q < 1)       begin : g_bad_q     $error("NUM_Q must be at least 1"); end
   endgenerate

   typedef struct packed {
      logic [NW-1:0] head;
      logic [NW-1:0] tail;
      logic [OW-1:0] hoff;
      logic [OW-1:0] toff;
      logic          empty;
   } desc_t;

   desc_t         desc_q [NUM_Q];
   logic [NW-1:0] free_head;
   logic [CW-1:0] free_cnt;
   logic [LW-1:0] pend_cnt;
   pend_kind_e    pend_kind;
   logic [QW-1:0] pend_q;

   desc_t         cur, nxt;
   logic          accept, need_node, tail_full, last_cell, head_done;
   logic          op_err, release_n, advance, do_alloc, rd_go;
   logic          lk_we;
   logic [NW-1:0] lk_waddr, lk_raddr, lk_rdata, map_node;
   logic [OW-1:0] map_off;
   logic [BW-1:0] map_buf;

   assign cmd_ready = (pend_cnt == 0);
   assign accept    = cmd_valid && cmd_ready;
   assign cur       = desc_q[cmd_qid];

   assign tail_full = (cur.toff == OW'(AGG - 1));
   assign head_done = (cur.hoff == OW'(AGG - 1));
   assign last_cell = (cur.head == cur.tail) && (cur.hoff == cur.toff);
   assign need_node = !cmd_deq && (cur.empty || tail_full);
   assign op_err    = cmd_deq ? cur.empty : (need_node && (free_cnt == 0));
   assign release_n = cmd_deq && !cur.empty && (last_cell || head_done);
   assign advance   = release_n && !last_cell;
   assign do_alloc  = accept && need_node && !op_err;
   assign rd_go     = do_alloc || (accept && advance);

   // link RAM: write the old free head behind a new tail or a released head
   assign lk_we    = accept && !op_err && ((need_node && !cur.empty) || release_n);
   assign lk_waddr = cmd_deq ? cur.head : cur.tail;
   assign lk_raddr = cmd_deq ? cur.head : free_head;

   assign map_node = cmd_deq ? cur.head : (need_node ? free_head : cur.tail);
   assign map_off  = cmd_deq ? cur.hoff : (need_node ? '0 : cur.toff + OW'(1));

   always_comb begin
      nxt = cur;
      if (!cmd_deq) begin
         if (need_node) begin
            nxt.tail  = free_head;
            nxt.toff  = '0;
            nxt.empty = 1'b0;
            if (cur.empty) begin
               nxt.head = free_head;
               nxt.hoff = '0;
            end
         end else begin
            nxt.toff = cur.toff + OW'(1);
         end
      end else begin
         if (last_cell)      nxt.empty = 1'b1;
         else if (head_done) nxt.hoff  = '0;
         else                nxt.hoff  = cur.hoff + OW'(1);
      end
   end

   aggq_link_ram #(.DEPTH(NUM_NODES), .LAT(LINK_LAT)) u_link (
      .clk(clk), .rst_n(rst_n),
      .we(lk_we), .waddr(lk_waddr), .wdata(free_head),
      .rd_en(rd_go), .raddr(lk_raddr), .rdata(lk_rdata)
   );

   aggq_buf_map #(.NW(NW), .AGG(AGG)) u_map (
      .node(map_node), .off(map_off), .buf_id(map_buf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int q = 0; q < NUM_Q; q++) desc_q[q] <= '{head: '0, tail: '0, hoff: '0, toff: '0, empty: 1'b1};
         free_head <= '0;
         free_cnt  <= CW'(NUM_NODES);
         pend_cnt  <= '0;
         pend_kind <= PK_NONE;
         pend_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_buf   <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_err <= op_err;
            rsp_buf <= op_err ? '0 : map_buf;
         end
         if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1'b1;
            if (pend_cnt == LW'(1)) begin
               if (pend_kind == PK_ALLOC)   free_head <= lk_rdata;
               if (pend_kind == PK_ADVANCE) desc_q[pend_q].head <= lk_rdata;
               pend_kind <= PK_NONE;
            end
         end
         if (accept && !op_err) begin
            desc_q[cmd_qid] <= nxt;
            if (do_alloc) free_cnt <= free_cnt - 1'b1;
            if (release_n) begin
               free_head <= cur.head;
               free_cnt  <= free_cnt + 1'b1;
            end
            if (rd_go) begin
               pend_cnt  <= LW'(LINK_LAT);
               pend_kind <= do_alloc ? PK_ALLOC : PK_ADVANCE;
               pend_q    <= cmd_qid;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   logic [LW:0] stall_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stall_run <= '0;
      else if (!cmd_ready) stall_run <= stall_run + 1'b1;
      else                 stall_run <= '0;
   end

   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !rsp_valid);
   p_empty_deq_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_deq && cur.empty) |=> (rsp_err && rsp_buf == '0));
   p_err_keeps_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_err) |=> $stable(free_cnt));
   p_free_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CW'(NUM_NODES));
   p_stall_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_run <= (LW + 1)'(LINK_LAT));
   p_qid_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(cmd_qid) < NUM_Q));
endmodule

// File: tb/aggq_mgr_tb.sv
`timescale 1ns/1ps
module aggq_mgr_tb;
   localparam int NQ  = 4;
   localparam int NN  = 8;
   localparam int AG  = 4;
   localparam int LAT = 2;
   localparam int QW  = 2;
   localparam int BW  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_deq = 1'b0;
   logic [QW-1:0] cmd_qid = '0;
   logic cmd_ready, rsp_valid, rsp_err;
   logic [BW-1:0] rsp_buf;

   always #2.5 clk = ~clk;

   aggq_mgr #(.NUM_Q(NQ), .NUM_NODES(NN), .AGG(AG), .LINK_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_deq(cmd_deq),
      .cmd_qid(cmd_qid), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
      .rsp_buf(rsp_buf), .rsp_err(rsp_err)
   );

   int checks = 0, fails = 0;
   int qb [NQ][$];
   int freel [$];
   bit was_rel [NN];
   int enq_ok = 0;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic op(input bit deq, input int q);
      int  eb = 0, st = 0, nd;
      bit  ee = 0;
      string bt;
      if (!deq) begin
         bit need = (qb[q].size() == 0) || (qb[q][$] % AG == AG - 1);
         bt = "R3";
         if (need && freel.size() == 0) ee = 1;
         else if (need) begin
            nd = freel.pop_front();
            bt = was_rel[nd] ? "R6" : "R4";
            eb = nd * AG; st = LAT;
         end else eb = qb[q][$] + 1;
         if (!ee) begin qb[q].push_back(eb); enq_ok++; end
      end else begin
         bt = "R5";
         if (qb[q].size() == 0) ee = 1;
         else begin
            eb = qb[q].pop_front();
            if (qb[q].size() == 0 || eb % AG == AG - 1) begin
               freel.push_front(eb / AG);
               was_rel[eb / AG] = 1;
               if (qb[q].size() != 0) st = LAT;
            end
         end
      end
      chk("R9 ready before command", int'(cmd_ready), 1);
      cmd_valid = 1; cmd_deq = deq; cmd_qid = QW'(q);
      @(negedge clk);
      cmd_valid = 0;
      chk("R2 rsp_valid", int'(rsp_valid), 1);
      chk(deq ? "R7 rsp_err" : "R8 rsp_err", int'(rsp_err), int'(ee));
      chk({bt, " rsp_buf"}, int'(rsp_buf), eb);
      for (int i = 0; i < st; i++) begin
         chk("R9 ready low during link read", int'(cmd_ready), 0);
         if (i > 0) chk("R2 rsp_valid idle", int'(rsp_valid), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish (R9 stall suspected)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      for (int i = 0; i < NN; i++) freel.push_back(i);
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", int'(cmd_ready), 1);
      chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 ready after reset", int'(cmd_ready), 1);
      chk("R1 rsp_valid after reset", int'(rsp_valid), 0);

      // every node free: NN*AG enqueues succeed, the next one fails
      for (int i = 0; i < NN * AG; i++) op(0, 3);
      chk("R1 cells accepted from reset", enq_ok, NN * AG);
      op(0, 3);
      op(0, 0);
      for (int i = 0; i < NN * AG; i++) op(1, 3);
      op(1, 3);

      // directed: empty dequeue, partial nodes, release and reuse
      op(1, 0);
      for (int i = 0; i < 5; i++) op(0, 0);
      op(0, 1); op(0, 1);
      op(0, 0);
      for (int i = 0; i < 4; i++) op(1, 0);
      op(0, 2);
      op(1, 1); op(1, 1);
      op(0, 1);
      op(1, 2); op(1, 2);

      // pseudo-random mix
      lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         op(lf[0] & lf[5], int'(lf[3:2]));
      end

      // exhaust, then drain everything
      for (int i = 0; i < 40; i++) op(0, i % NQ);
      for (int q = 0; q < NQ; q++)
         for (int i = 0; i < NN * AG + 1; i++) op(1, q);
      for (int i = 0; i < 6; i++) op(0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule